// File: doc/BRIEF.md
# PSRAM Configuration-Register Access Sequencer

This block sits next to the host controller of an asynchronous pseudo-static RAM. It reaches the memory's configuration register over the ordinary asynchronous bus, with no extra pin, by issuing a fixed train of four bus cycles that all target the highest word address. The first two cycles are reads and the third is a write of zero. The fourth cycle either writes the new register value or reads the current one back. Chip enable goes high between cycles for a guard time that is at least as long as the memory requires before the register read cycle.

The block also drives the memory's active-low sleep pin. Pulling that pin low puts the device into whichever low-power mode the register's sleep-select bit names. When the sleep pin is released, the block stays busy for a fixed recovery period. A register load that would clear the sleep-select bit, and so select deep power-down through the software path, is refused.

Commands arrive on a valid/ready channel. A command transfers on a rising clock edge where `cmd_valid` and `cmd_ready` are both high, and its opcode and value are captured on that edge. While `cmd_ready` is low the host must keep `cmd_valid` and its payload steady or withdraw them, and nothing is accepted. Results come back as a one-clock `done` pulse, with `err` raised in the same clock when the command was refused.

Top module: `psram_cfg_seq`

## Requirements
- R1: After reset, chip enable, output enable, write enable and the sleep pin are all high (inactive), `mem_dq_oe` is 0, `busy` and `done` are 0, and `cmd_ready` is 1.
- R2: A load (opcode 0) or read (opcode 1) issues exactly four chip-enable-low windows, each CYCLE_CLKS clocks long, all with `mem_addr` all ones. Windows 1 and 2 are reads (output enable low). Window 3 is a write (write enable low) that drives 0x0000 on `mem_dq_out`.
- R3: Before every chip-enable-low window, chip enable has been high for at least GUARD_CLKS clocks.
- R4: In a load, window 4 is a write with `mem_dq_oe` high that drives the captured `cmd_cr` value.
- R5: In a read, window 4 holds output enable low with `mem_dq_oe` low. The `mem_dq_in` value present on the last clock of that window appears on `rd_data` when `done` pulses.
- R6: `done` is a single-clock pulse per accepted command. For a load or read, `busy` is high for exactly 4*(GUARD_CLKS+CYCLE_CLKS) clocks, and `done` comes in the clock after the last of them. `err` is only ever high together with `done`.
- R7: A load whose `cmd_cr` bit SLEEP_BIT (bit 4) is 0 is refused. No bus cycle occurs, and `done` and `err` pulse in the clock after acceptance.
- R8: An enter-sleep command (opcode 2) drives `mem_zz_n` low from the clock after acceptance and pulses `done` in that same clock without `err`.
- R9: While asleep, any opcode other than wake (3) is refused with `done` and `err`. `mem_zz_n` stays low and no bus cycle occurs.
- R10: A wake command (opcode 3) while asleep drives `mem_zz_n` high. `busy` then stays high for exactly RECOVER_CLKS clocks, after which `done` pulses.
- R11: A wake command while not asleep completes in the next clock with `done`, no `err`, no `busy` and no pin change.
- R12: `cmd_ready` is low whenever `busy` is high. A `cmd_valid` raised and dropped while not ready starts no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this clock |
| cmd_op | input | 2 | 0 load, 1 read, 2 enter sleep, 3 wake |
| cmd_cr | input | DATA_W | Register value for a load |
| busy | output | 1 | Bus sequence or wake recovery in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Command refused (with done) |
| rd_data | output | DATA_W | Register value from the last read |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Byte lane enables, active low |
| mem_dq_out | output | DATA_W | Write data to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Read data from memory |
| mem_zz_n | output | 1 | Sleep pin, active low |

## Verification
The assertions assume that `cmd_op` is a defined value whenever `cmd_valid` is high. They also assume that `mem_dq_in` is only of interest while output enable is low, and that reset is held over the first clock edges. The stimulus applies reset before any command and changes inputs only on falling edges. The memory model in the bench returns a distinct word only during the fourth read window and a different word in the earlier ones, so the captured value shows which cycle was sampled. Timing parameters are shortened so that every window and the recovery period can be counted clock by clock.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_READ  = 2'd1,
    OP_SLEEP = 2'd2,
    OP_WAKE  = 2'd3
  } cfg_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_ACCESS,
    ST_SLEEP,
    ST_WAKE
  } seq_state_e;

  localparam int unsigned NUM_PHASES = 4;
  localparam int unsigned PH_W       = $clog2(NUM_PHASES);
  localparam logic [PH_W-1:0] PH_KEY  = PH_W'(2);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NUM_PHASES - 1);
endpackage

// File: rtl/psram_cfg_timer.sv
module psram_cfg_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/psram_cfg_busdrv.sv
module psram_cfg_busdrv
  import psram_cfg_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  seq_state_e        state,
  input  logic [PH_W-1:0]   phase,
  input  cfg_op_e           op_q,
  input  logic [DATA_W-1:0] cr_q,
  output logic [ADDR_W-1:0] addr,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W/8-1:0] be_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic active;
  logic rd_kind;

  assign active  = (state == ST_ACCESS);
  assign rd_kind = (phase < PH_KEY) || ((phase == PH_LAST) && (op_q == OP_READ));

  assign ce_n   = ~active;
  assign oe_n   = ~(active && rd_kind);
  assign we_n   = ~(active && !rd_kind);
  assign dq_oe  = active && !rd_kind;
  assign addr   = active ? TOP_ADDR : '0;
  assign dq_out = (active && phase == PH_LAST) ? cr_q : '0;

  for (genvar lane = 0; lane < BE_W; lane++) begin : g_lane
    assign be_n[lane] = ~active;
  end
endmodule

// File: rtl/psram_cfg_ctrl.sv
module psram_cfg_ctrl
  import psram_cfg_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SLEEP_BIT    = 4,
  parameter int GUARD_CLKS   = 19,
  parameter int CYCLE_CLKS   = 9,
  parameter int RECOVER_CLKS = 18750,
  parameter int CNT_W        = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_cr,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output seq_state_e        state,
  output logic [PH_W-1:0]   phase,
  output cfg_op_e           op_q,
  output logic [DATA_W-1:0] cr_q,
  output logic              zz_n,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] GUARD_V = CNT_W'(GUARD_CLKS - 1);
  localparam logic [CNT_W-1:0] CYCLE_V = CNT_W'(CYCLE_CLKS - 1);
  localparam logic [CNT_W-1:0] RECOV_V = CNT_W'(RECOVER_CLKS - 1);

  cfg_op_e in_op;
  logic    accept;
  logic    seq_start;

  assign in_op     = cfg_op_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE) || (state == ST_SLEEP);
  assign accept    = cmd_valid && cmd_ready;
  assign seq_start = accept && (state == ST_IDLE) &&
                     ((in_op == OP_READ) || (in_op == OP_LOAD && cmd_cr[SLEEP_BIT]));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (seq_start) begin
      tmr_load = 1'b1;
      tmr_val  = GUARD_V;
    end else if (state == ST_GUARD && tmr_zero) begin
      tmr_load = 1'b1;
      tmr_val  = CYCLE_V;
    end else if (state == ST_ACCESS && tmr_zero && phase != PH_LAST) begin
      tmr_load = 1'b1;
      tmr_val  = GUARD_V;
    end else if (state == ST_SLEEP && accept && in_op == OP_WAKE) begin
      tmr_load = 1'b1;
      tmr_val  = RECOV_V;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= '0;
      op_q    <= OP_LOAD;
      cr_q    <= '0;
      zz_n    <= 1'b1;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (seq_start) begin
              state <= ST_GUARD;
              phase <= '0;
              op_q  <= in_op;
              cr_q  <= cmd_cr;
            end else if (in_op == OP_SLEEP) begin
              state <= ST_SLEEP;
              zz_n  <= 1'b0;
              done  <= 1'b1;
            end else if (in_op == OP_WAKE) begin
              done <= 1'b1;
            end else begin
              done <= 1'b1;
              err  <= 1'b1;
            end
          end
        end
        ST_GUARD: begin
          if (tmr_zero) state <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (tmr_zero) begin
            if (phase == PH_LAST) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              if (op_q == OP_READ) rd_data <= dq_in;
            end else begin
              phase <= phase + 1'b1;
              state <= ST_GUARD;
            end
          end
        end
        ST_SLEEP: begin
          if (accept) begin
            if (in_op == OP_WAKE) begin
              state <= ST_WAKE;
              zz_n  <= 1'b1;
            end else begin
              done <= 1'b1;
              err  <= 1'b1;
            end
          end
        end
        ST_WAKE: begin
          if (tmr_zero) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  reject_dpd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state == ST_IDLE && in_op == OP_LOAD && !cmd_cr[SLEEP_BIT])
      |=> (done && err && state == ST_IDLE));

  // R8
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state == ST_IDLE && in_op == OP_SLEEP) |=> (!zz_n && done && !err));

  // R9
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && !(accept && in_op == OP_WAKE)) |=> !zz_n);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

// File: rtl/psram_cfg_seq.sv
module psram_cfg_seq
  import psram_cfg_pkg::*;
#(
  parameter int ADDR_W       = 21,
  parameter int DATA_W       = 16,
  parameter int SLEEP_BIT    = 4,
  parameter int GUARD_CLKS   = 19,
  parameter int CYCLE_CLKS   = 9,
  parameter int RECOVER_CLKS = 18750
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  input  logic [DATA_W-1:0]   cmd_cr,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [DATA_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in,
  output logic                mem_zz_n
);
  localparam int MAX_GC = (GUARD_CLKS > CYCLE_CLKS) ? GUARD_CLKS : CYCLE_CLKS;
  localparam int MAX_T  = (MAX_GC > RECOVER_CLKS) ? MAX_GC : RECOVER_CLKS;
  localparam int CNT_W  = $clog2(MAX_T + 1);
  localparam int HR_W   = $clog2(GUARD_CLKS + 1) + 1;

  seq_state_e        state;
  logic [PH_W-1:0]   phase;
  cfg_op_e           op_q;
  logic [DATA_W-1:0] cr_q;
  logic              tmr_zero;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;

  psram_cfg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  psram_cfg_ctrl #(
    .DATA_W       (DATA_W),
    .SLEEP_BIT    (SLEEP_BIT),
    .GUARD_CLKS   (GUARD_CLKS),
    .CYCLE_CLKS   (CYCLE_CLKS),
    .RECOVER_CLKS (RECOVER_CLKS),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_cr    (cmd_cr),
    .dq_in     (mem_dq_in),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .state     (state),
    .phase     (phase),
    .op_q      (op_q),
    .cr_q      (cr_q),
    .zz_n      (mem_zz_n),
    .done      (done),
    .err       (err),
    .rd_data   (rd_data)
  );

  psram_cfg_busdrv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .state  (state),
    .phase  (phase),
    .op_q   (op_q),
    .cr_q   (cr_q),
    .addr   (mem_addr),
    .ce_n   (mem_ce_n),
    .oe_n   (mem_oe_n),
    .we_n   (mem_we_n),
    .be_n   (mem_be_n),
    .dq_out (mem_dq_out),
    .dq_oe  (mem_dq_oe)
  );

  assign busy = (state == ST_GUARD) || (state == ST_ACCESS) || (state == ST_WAKE);

  // Run length of chip-enable-high clocks, saturating, for the guard check.
  logic [HR_W-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                        hi_run <= HR_W'(GUARD_CLKS);
    else if (!mem_ce_n)                hi_run <= '0;
    else if (hi_run < HR_W'(GUARD_CLKS)) hi_run <= hi_run + 1'b1;
  end

  // R3
  ce_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (hi_run >= HR_W'(GUARD_CLKS)));

  // R2
  top_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (mem_addr == {ADDR_W{1'b1}}));

  // R2
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R10
  wake_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_zz_n) |-> busy);

  // R12
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
endmodule

// File: tb/psram_cfg_seq_test.sv
module psram_cfg_seq_test;
  import psram_cfg_pkg::*;

  localparam int AW = 21;
  localparam int DW = 16;
  localparam int G  = 4;
  localparam int C  = 3;
  localparam int R  = 10;
  localparam int SEQ_T = 4 * (G + C);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [DW-1:0] cmd_cr = '0;
  logic          busy, done, err;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_zz_n;
  logic [1:0]    mem_be_n;
  logic [DW-1:0] mem_dq_out, mem_dq_in;
  logic [DW-1:0] dev_val = 16'hA5C3;

  int n_tests = 0;
  int n_fail  = 0;

  // Monitor of chip-enable windows.
  int        win_cnt = 0;
  int        cur_len = 0;
  int        hi_len  = 100;
  int        guard_bad = 0;
  int        w_len [8];
  bit        w_wr [8];
  bit        w_rd [8];
  bit        w_addr_ok [8];
  bit        w_dqoe [8];
  logic [15:0] w_data [8];

  assign mem_dq_in = !mem_oe_n ? ((win_cnt == 3) ? dev_val : 16'h1234) : 16'h0000;

  psram_cfg_seq #(
    .ADDR_W(AW), .DATA_W(DW), .SLEEP_BIT(4),
    .GUARD_CLKS(G), .CYCLE_CLKS(C), .RECOVER_CLKS(R)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_cr(cmd_cr), .busy(busy), .done(done), .err(err),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_zz_n(mem_zz_n)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n) begin
        if (cur_len == 0) begin
          if (hi_len < G) guard_bad++;
          if (win_cnt < 8) begin
            w_wr[win_cnt]      = !mem_we_n;
            w_rd[win_cnt]      = !mem_oe_n;
            w_addr_ok[win_cnt] = (mem_addr == {AW{1'b1}});
            w_dqoe[win_cnt]    = mem_dq_oe;
            w_data[win_cnt]    = mem_dq_out;
          end
        end
        cur_len++;
        hi_len = 0;
      end else begin
        if (cur_len > 0) begin
          if (win_cnt < 8) w_len[win_cnt] = cur_len;
          win_cnt++;
          cur_len = 0;
        end
        hi_len++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    win_cnt   = 0;
    guard_bad = 0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [15:0] cr,
                         output int busy_n, output int lat, output bit errf, output int rdy_busy);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_cr    = cr;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_n = 0; lat = 1; rdy_busy = 0;
    while (!done && lat < 5000) begin
      if (busy) busy_n++;
      if (busy && cmd_ready) rdy_busy++;
      @(negedge clk);
      lat++;
    end
    errf = err;
    @(negedge clk);
    check(!done, "R6 done lasts one clock", 32'(done), 0);
  endtask

  task automatic t_reset();
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 bus strobes idle",
          {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 7);
    check(mem_zz_n == 1'b1, "R1 sleep pin high", 32'(mem_zz_n), 1);
    check(!busy && !done && !mem_dq_oe, "R1 busy/done/dq_oe low",
          {29'd0, busy, done, mem_dq_oe}, 0);
    check(cmd_ready == 1'b1, "R1 ready after reset", 32'(cmd_ready), 1);
  endtask

  task automatic t_load();
    int b, l, rb; bit e;
    clear_mon();
    run_cmd(OP_LOAD, 16'h0013, b, l, e, rb);
    check(win_cnt == 4, "R2 load window count", win_cnt, 4);
    for (int i = 0; i < 4; i++) begin
      check(w_len[i] == C, "R2 window length", w_len[i], C);
      check(w_addr_ok[i], "R2 window at top address", 32'(w_addr_ok[i]), 1);
    end
    check(w_rd[0] && w_rd[1] && !w_wr[0] && !w_wr[1], "R2 first two are reads",
          {28'd0, w_rd[0], w_rd[1], w_wr[0], w_wr[1]}, 12);
    check(w_wr[2] && w_data[2] == 16'h0000, "R2 third is zero write", {15'd0, w_wr[2], w_data[2]}, 32'h10000);
    check(w_wr[3] && w_dqoe[3] && w_data[3] == 16'h0013, "R4 load data write",
          {14'd0, w_wr[3], w_dqoe[3], w_data[3]}, 32'h30013);
    check(guard_bad == 0, "R3 guard before each window", guard_bad, 0);
    check(b == SEQ_T, "R6 load busy clocks", b, SEQ_T);
    check(l == SEQ_T + 1, "R6 load done latency", l, SEQ_T + 1);
    check(!e, "R6 load no error", 32'(e), 0);
    check(rb == 0, "R12 ready low while busy", rb, 0);
  endtask

  task automatic t_read();
    int b, l, rb; bit e;
    clear_mon();
    dev_val = 16'hA5C3;
    run_cmd(OP_READ, 16'hFFFF, b, l, e, rb);
    check(win_cnt == 4, "R2 read window count", win_cnt, 4);
    check(w_rd[3] && !w_dqoe[3] && !w_wr[3], "R5 fourth window is a read",
          {29'd0, w_rd[3], w_dqoe[3], w_wr[3]}, 4);
    check(w_wr[2] && w_data[2] == 16'h0000, "R2 read third is zero write", {15'd0, w_wr[2], w_data[2]}, 32'h10000);
    check(rd_data == 16'hA5C3, "R5 read data", 32'(rd_data), 32'hA5C3);
    check(guard_bad == 0, "R3 read guard", guard_bad, 0);
    check(l == SEQ_T + 1 && !e, "R6 read latency", l, SEQ_T + 1);
  endtask

  task automatic t_reject();
    int b, l, rb; bit e;
    clear_mon();
    run_cmd(OP_LOAD, 16'h0005, b, l, e, rb);
    check(e, "R7 deep power-down load refused", 32'(e), 1);
    check(l == 1 && b == 0, "R7 refusal latency", l, 1);
    repeat (G + C + 2) @(negedge clk);
    check(win_cnt == 0, "R7 no bus cycle", win_cnt, 0);
  endtask

  task automatic t_backpressure();
    int lat;
    clear_mon();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = OP_LOAD; cmd_cr = 16'h0017;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = OP_READ;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    repeat (G + C + 6) @(negedge clk);
    check(win_cnt == 4, "R12 offer while busy ignored", win_cnt, 4);
    check(!busy, "R12 idle after ignored offer", 32'(busy), 0);
  endtask

  task automatic t_sleep();
    int b, l, rb; bit e;
    run_cmd(OP_SLEEP, 16'h0000, b, l, e, rb);
    check(!mem_zz_n, "R8 sleep pin low", 32'(mem_zz_n), 0);
    check(l == 1 && !e, "R8 sleep done latency", l, 1);
  endtask

  task automatic t_sleep_reject();
    int b, l, rb; bit e;
    clear_mon();
    run_cmd(OP_READ, 16'h0000, b, l, e, rb);
    check(e && l == 1, "R9 command refused while asleep", 32'(e), 1);
    repeat (G + C + 2) @(negedge clk);
    check(!mem_zz_n, "R9 sleep pin stays low", 32'(mem_zz_n), 0);
    check(win_cnt == 0, "R9 no bus cycle while asleep", win_cnt, 0);
  endtask

  task automatic t_wake();
    int b, l, rb; bit e;
    run_cmd(OP_WAKE, 16'h0000, b, l, e, rb);
    check(mem_zz_n, "R10 sleep pin released", 32'(mem_zz_n), 1);
    check(b == R, "R10 recovery busy clocks", b, R);
    check(l == R + 1 && !e, "R10 wake done latency", l, R + 1);
  endtask

  task automatic t_wake_idle();
    int b, l, rb; bit e;
    run_cmd(OP_WAKE, 16'h0000, b, l, e, rb);
    check(l == 1 && b == 0, "R11 wake when awake latency", l, 1);
    check(!e && mem_zz_n, "R11 no error, pin unchanged", {30'd0, e, mem_zz_n}, 1);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_read();
    t_reject();
    t_backpressure();
    t_sleep();
    t_sleep_reject();
    t_wake();
    t_wake_idle();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule